// File: doc/BRIEF.md
# Virtually Indexed Physically Tagged Data Cache

This block is the lookup and fill path of a 64 KB, 16-way set-associative, write-back data cache. It serves a 24-bit virtual address space with 4 KB pages and 64-byte lines. The 12 low address bits are never translated, and the set index (6 bits) and word select (4 bits) are both taken from them. The tag and data arrays can therefore be addressed as soon as a request arrives, while a separate translation unit maps the 12-bit virtual page number to a physical page number.

The full physical page number is stored as the tag of each way. Hit detection compares the translated page against the 16 tags of the selected set. Two virtual pages that map to one physical page therefore meet the same line. They can never create two cached copies.

On a miss, a per-set round-robin pointer picks the victim. A dirty victim is written back as a whole line before the new line is fetched. Stores allocate on a miss and mark the line dirty; they never write memory directly. Only one request is in flight at a time.

Top module: `vipt_cache`

## Requirements
- R1: After reset, every way of every set is invalid. `req_ready` is high and `resp_valid`, `xl_req_valid` and `mem_req_valid` are low. The first access to any address therefore misses.
- R2: A request address must be word aligned (`req_vaddr[1:0]` = 0). The set is `req_vaddr[11:6]` and the word within the line is `req_vaddr[5:2]`. The translation request carries `req_vaddr[23:12]`. A memory line address is {physical page in bits [17:6], set in bits [5:0]}.
- R3: While a translation is pending (`xl_req_valid` high without `xl_resp_valid`), the block stays stalled for any number of cycles. During that time it issues no memory request and no response.
- R4: A hit gives `resp_valid` exactly one cycle after the cycle in which `xl_resp_valid` is seen, with no memory traffic. A load returns the stored word; a store returns its own write data.
- R5: Tags are physical. An access through any virtual page that maps to the same physical page hits the same line and sees earlier stores made through another alias, with no refill.
- R6: A miss whose victim is invalid or clean issues exactly one memory read, at line address {translated page, set}, and no memory write.
- R7: A store hit updates the cache only and marks the line dirty, with no memory write. When a dirty line is evicted, the whole line is written to its own line address before the refill read is issued. The stored data is preserved in memory.
- R8: Each set has its own victim pointer. It starts at way 0 after reset and advances by one (wrapping) on every fill in that set. Fills in one set never move another set's pointer.
- R9: A store miss allocates. The refilled line is installed with the store word merged in and is marked dirty. The other words of the line hold the memory contents.
- R10: Only one request is in flight. `req_ready` is high only when the block is idle, and it is low from acceptance until the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | CPU request valid |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_write | input | 1 | 1 = store, 0 = load |
| req_vaddr | input | 24 | Virtual byte address, word aligned |
| req_wdata | input | 32 | Store data |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 32 | Load data, or store data for a store |
| xl_req_valid | output | 1 | Translation wanted for `xl_req_vpn` |
| xl_req_vpn | output | 12 | Virtual page number to translate |
| xl_resp_valid | input | 1 | Translation result valid this cycle |
| xl_resp_ppn | input | 12 | Physical page number |
| mem_req_valid | output | 1 | Memory line request, held until answered |
| mem_req_write | output | 1 | 1 = write-back, 0 = refill read |
| mem_req_laddr | output | 18 | Physical line address |
| mem_req_wline | output | 512 | Line data for a write-back |
| mem_resp_valid | input | 1 | Memory has completed the request this cycle |
| mem_resp_rline | input | 512 | Refill line data |

## Verification
The bench targets the points where a virtually indexed, physically tagged design typically breaks. Stalled translations are tested, because a design that compared tags early would answer or go to memory before the page was known. Aliased virtual pages are tested, because a design using virtual tags would refill a second copy and return stale data. A full set is overfilled so that a dirty line is evicted: a wrong pointer step would evict a line that should survive, and a skipped or misaddressed write-back would lose the stored word when it is read back. Store misses are checked for word merging, and a randomized mix over two heavily conflicting sets compares every load against a physical-address golden memory.

// File: rtl/vipt_pkg.sv
`timescale 1ns/1ps
package vipt_pkg;
    localparam int VADDR_W    = 24;
    localparam int PADDR_W    = 24;
    localparam int PAGE_OFF_W = 12;
    localparam int LINE_OFF_W = 6;
    localparam int WORD_W     = 32;
    localparam int NUM_WAYS   = 16;

    typedef enum logic [1:0] {
        CS_IDLE,
        CS_XLATE,
        CS_WBACK,
        CS_FILL
    } ctl_state_e;
endpackage

// File: rtl/vipt_tag_store.sv
`timescale 1ns/1ps
module vipt_tag_store #(
    parameter int SETS  = 64,
    parameter int WAYS  = 16,
    parameter int TAG_W = 12,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [SET_W-1:0]            rd_set,
    input  logic [TAG_W-1:0]            cmp_tag,
    output logic [WAYS-1:0]             way_hit,
    output logic [WAYS-1:0]             way_valid,
    output logic [WAYS-1:0]             way_dirty,
    output logic [WAYS-1:0][TAG_W-1:0]  way_tag,
    input  logic                        wr_en,
    input  logic [SET_W-1:0]            wr_set,
    input  logic [WAY_W-1:0]            wr_way,
    input  logic                        wr_valid,
    input  logic                        wr_dirty,
    input  logic [TAG_W-1:0]            wr_tag
);
    logic [WAYS-1:0]  valid_q [SETS];
    logic [WAYS-1:0]  dirty_q [SETS];
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
            end
        end else if (wr_en) begin
            valid_q[wr_set][wr_way] <= wr_valid;
            dirty_q[wr_set][wr_way] <= wr_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_set][wr_way] <= wr_tag;
    end

    // one comparator per way, all working on the same set in parallel
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign way_valid[w] = valid_q[rd_set][w];
        assign way_dirty[w] = dirty_q[rd_set][w];
        assign way_tag[w]   = tag_q[rd_set][w];
        assign way_hit[w]   = valid_q[rd_set][w] && (tag_q[rd_set][w] == cmp_tag);
    end

    // a physical line lives in at most one way of its set
    assert_hit_unique_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(way_hit));

    assert_cleared_by_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (way_valid == '0));
endmodule

// File: rtl/vipt_line_store.sv
`timescale 1ns/1ps
module vipt_line_store #(
    parameter int ENTRIES = 1024,
    parameter int LINE_W  = 512,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LINE_W-1:0] wr_line
);
    logic [LINE_W-1:0] line_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en) line_q[wr_idx] <= wr_line;
    end

    assign rd_line = line_q[rd_idx];
endmodule

// File: rtl/vipt_victim_rr.sv
`timescale 1ns/1ps
module vipt_victim_rr #(
    parameter int SETS = 64,
    parameter int WAYS = 16,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] set_i,
    input  logic             advance,
    output logic [WAY_W-1:0] victim_o
);
    logic [WAY_W-1:0] ptr_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
        end else if (advance) begin
            ptr_q[set_i] <= ptr_q[set_i] + WAY_W'(1);
        end
    end

    assign victim_o = ptr_q[set_i];

    assert_rr_step_R8: assert property (@(posedge clk) disable iff (rst)
        advance |=> (ptr_q[$past(set_i)] == $past(victim_o) + WAY_W'(1)));
endmodule

// File: rtl/vipt_cache.sv
`timescale 1ns/1ps
module vipt_cache
    import vipt_pkg::*;
#(
    parameter int VA_W   = VADDR_W,
    parameter int PA_W   = PADDR_W,
    parameter int POFF_W = PAGE_OFF_W,
    parameter int LOFF_W = LINE_OFF_W,
    parameter int DW     = WORD_W,
    parameter int WAYS   = NUM_WAYS,
    localparam int VPN_W   = VA_W - POFF_W,
    localparam int PPN_W   = PA_W - POFF_W,
    localparam int SET_W   = POFF_W - LOFF_W,
    localparam int SETS    = 1 << SET_W,
    localparam int WAY_W   = $clog2(WAYS),
    localparam int BSEL_W  = $clog2(DW / 8),
    localparam int WSEL_W  = LOFF_W - BSEL_W,
    localparam int LINE_W  = DW << WSEL_W,
    localparam int LADDR_W = PPN_W + SET_W,
    localparam int ENTRY_W = SET_W + WAY_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [DW-1:0]      req_wdata,
    output logic               resp_valid,
    output logic [DW-1:0]      resp_rdata,
    output logic               xl_req_valid,
    output logic [VPN_W-1:0]   xl_req_vpn,
    input  logic               xl_resp_valid,
    input  logic [PPN_W-1:0]   xl_resp_ppn,
    output logic               mem_req_valid,
    output logic               mem_req_write,
    output logic [LADDR_W-1:0] mem_req_laddr,
    output logic [LINE_W-1:0]  mem_req_wline,
    input  logic               mem_resp_valid,
    input  logic [LINE_W-1:0]  mem_resp_rline
);
    function automatic logic [WAY_W-1:0] lowest_way(input logic [WAYS-1:0] v);
        lowest_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) if (v[i]) lowest_way = WAY_W'(i);
    endfunction

    function automatic logic [DW-1:0] pick_word(input logic [LINE_W-1:0] l,
                                                 input logic [WSEL_W-1:0] s);
        pick_word = l[int'(s)*DW +: DW];
    endfunction

    function automatic logic [LINE_W-1:0] merge_word(input logic [LINE_W-1:0] l,
                                                      input logic [WSEL_W-1:0] s,
                                                      input logic [DW-1:0]     d);
        merge_word = l;
        merge_word[int'(s)*DW +: DW] = d;
    endfunction

    ctl_state_e        state_q, state_d;
    logic              q_write;
    logic [VPN_W-1:0]  q_vpn;
    logic [SET_W-1:0]  q_set;
    logic [WSEL_W-1:0] q_wsel;
    logic [DW-1:0]     q_wdata;
    logic [PPN_W-1:0]  q_ppn;
    logic [WAY_W-1:0]  q_vic;
    logic              resp_valid_q;
    logic [DW-1:0]     resp_rdata_q;

    logic [WAYS-1:0]             way_hit, way_valid, way_dirty;
    logic [WAYS-1:0][PPN_W-1:0]  way_tag;
    logic [WAY_W-1:0]            rr_way, hit_way, sel_way;
    logic [LINE_W-1:0]           rd_line;
    logic                        accept, hit_any, lookup_done, fill_done, vic_dirty;
    logic                        tag_we, tag_wvalid, tag_wdirty;
    logic [PPN_W-1:0]            tag_wtag;
    logic                        data_we;
    logic [LINE_W-1:0]           data_wline;

    assign req_ready   = (state_q == CS_IDLE);
    assign accept      = req_valid && req_ready;
    assign hit_way     = lowest_way(way_hit);
    assign hit_any     = |way_hit;
    assign lookup_done = (state_q == CS_XLATE) && xl_resp_valid;
    assign fill_done   = (state_q == CS_FILL) && mem_resp_valid;
    assign sel_way     = (state_q == CS_XLATE) ? hit_way : q_vic;
    assign vic_dirty   = way_valid[rr_way] && way_dirty[rr_way];

    vipt_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(PPN_W)) u_tags (
        .clk       (clk),
        .rst       (rst),
        .rd_set    (q_set),
        .cmp_tag   (xl_resp_ppn),
        .way_hit   (way_hit),
        .way_valid (way_valid),
        .way_dirty (way_dirty),
        .way_tag   (way_tag),
        .wr_en     (tag_we),
        .wr_set    (q_set),
        .wr_way    (sel_way),
        .wr_valid  (tag_wvalid),
        .wr_dirty  (tag_wdirty),
        .wr_tag    (tag_wtag)
    );

    vipt_line_store #(.ENTRIES(SETS * WAYS), .LINE_W(LINE_W)) u_lines (
        .clk     (clk),
        .rd_idx  (ENTRY_W'({q_set, sel_way})),
        .rd_line (rd_line),
        .wr_en   (data_we),
        .wr_idx  (ENTRY_W'({q_set, sel_way})),
        .wr_line (data_wline)
    );

    vipt_victim_rr #(.SETS(SETS), .WAYS(WAYS)) u_victim (
        .clk      (clk),
        .rst      (rst),
        .set_i    (q_set),
        .advance  (fill_done),
        .victim_o (rr_way)
    );

    always_comb begin
        state_d    = state_q;
        tag_we     = 1'b0;
        tag_wvalid = 1'b0;
        tag_wdirty = 1'b0;
        tag_wtag   = q_ppn;
        data_we    = 1'b0;
        data_wline = rd_line;
        unique case (state_q)
            CS_IDLE: begin
                if (req_valid) state_d = CS_XLATE;
            end
            CS_XLATE: begin
                if (xl_resp_valid) begin
                    if (hit_any) begin
                        state_d = CS_IDLE;
                        if (q_write) begin
                            tag_we     = 1'b1;
                            tag_wvalid = 1'b1;
                            tag_wdirty = 1'b1;
                            tag_wtag   = xl_resp_ppn;
                            data_we    = 1'b1;
                            data_wline = merge_word(rd_line, q_wsel, q_wdata);
                        end
                    end else begin
                        state_d = vic_dirty ? CS_WBACK : CS_FILL;
                    end
                end
            end
            CS_WBACK: begin
                if (mem_resp_valid) begin
                    tag_we   = 1'b1;
                    tag_wtag = way_tag[q_vic];
                    state_d  = CS_FILL;
                end
            end
            CS_FILL: begin
                if (mem_resp_valid) begin
                    tag_we     = 1'b1;
                    tag_wvalid = 1'b1;
                    tag_wdirty = q_write;
                    data_we    = 1'b1;
                    data_wline = q_write ? merge_word(mem_resp_rline, q_wsel, q_wdata)
                                         : mem_resp_rline;
                    state_d    = CS_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= CS_IDLE;
            resp_valid_q <= 1'b0;
            resp_rdata_q <= '0;
        end else begin
            state_q      <= state_d;
            resp_valid_q <= 1'b0;
            if (lookup_done && hit_any) begin
                resp_valid_q <= 1'b1;
                resp_rdata_q <= q_write ? q_wdata : pick_word(rd_line, q_wsel);
            end
            if (fill_done) begin
                resp_valid_q <= 1'b1;
                resp_rdata_q <= q_write ? q_wdata : pick_word(mem_resp_rline, q_wsel);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            q_write <= req_write;
            q_vpn   <= req_vaddr[VA_W-1:POFF_W];
            q_set   <= req_vaddr[POFF_W-1:LOFF_W];
            q_wsel  <= req_vaddr[LOFF_W-1:BSEL_W];
            q_wdata <= req_wdata;
        end
        if (lookup_done && !hit_any) begin
            q_ppn <= xl_resp_ppn;
            q_vic <= rr_way;
        end
    end

    assign resp_valid    = resp_valid_q;
    assign resp_rdata    = resp_rdata_q;
    assign xl_req_valid  = (state_q == CS_XLATE);
    assign xl_req_vpn    = q_vpn;
    assign mem_req_valid = (state_q == CS_WBACK) || (state_q == CS_FILL);
    assign mem_req_write = (state_q == CS_WBACK);
    assign mem_req_laddr = (state_q == CS_WBACK) ? {way_tag[q_vic], q_set} : {q_ppn, q_set};
    assign mem_req_wline = rd_line;

    assert_aligned_req_R2: assert property (@(posedge clk) disable iff (rst)
        accept |-> (req_vaddr[BSEL_W-1:0] == '0));

    assert_quiet_while_xlate_R3: assert property (@(posedge clk) disable iff (rst)
        xl_req_valid |-> (!mem_req_valid && !resp_valid));

    assert_hit_answers_next_R4: assert property (@(posedge clk) disable iff (rst)
        (xl_req_valid && xl_resp_valid && (|way_hit)) |=> resp_valid);

    assert_resp_has_cause_R4: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> ($past(xl_resp_valid) || $past(mem_resp_valid)));

    assert_refill_after_clean_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_write) |-> !(way_valid[q_vic] && way_dirty[q_vic]));

    assert_ready_only_idle_R10: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!xl_req_valid && !mem_req_valid));
endmodule

// File: tb/test_vipt_cache.sv
`timescale 1ns/1ps
module test_vipt_cache;
    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid, req_write;
    logic         req_ready;
    logic [23:0]  req_vaddr;
    logic [31:0]  req_wdata;
    logic         resp_valid;
    logic [31:0]  resp_rdata;
    logic         xl_req_valid;
    logic [11:0]  xl_req_vpn;
    logic         xl_resp_valid;
    logic [11:0]  xl_resp_ppn;
    logic         mem_req_valid, mem_req_write;
    logic [17:0]  mem_req_laddr;
    logic [511:0] mem_req_wline;
    logic         mem_resp_valid;
    logic [511:0] mem_resp_rline;

    always #2.5 clk = ~clk;

    vipt_cache i_vipt_cache (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_vaddr(req_vaddr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .xl_req_valid(xl_req_valid), .xl_req_vpn(xl_req_vpn),
        .xl_resp_valid(xl_resp_valid), .xl_resp_ppn(xl_resp_ppn),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_laddr(mem_req_laddr), .mem_req_wline(mem_req_wline),
        .mem_resp_valid(mem_resp_valid), .mem_resp_rline(mem_resp_rline)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    logic [511:0] mem_lines [int];
    logic [31:0]  gold [int];

    logic [31:0] a_rdata;
    int a_nrd, a_nwr, a_wb_la, a_rd_la, a_lat;
    bit a_stall_bad, a_ready_bad, a_vpn_bad;
    bit any_stall_bad = 0, any_ready_bad = 0, any_vpn_bad = 0;

    function automatic logic [11:0] page_map(input logic [11:0] vpn);
        if (vpn == 12'hAAA) return 12'h123 ^ 12'h3C5;   // alias of page 0x123
        return vpn ^ 12'h3C5;
    endfunction

    function automatic logic [23:0] mk_va(input logic [11:0] vpn, input int set, input int w);
        return {vpn, 6'(set), 4'(w), 2'b00};
    endfunction

    function automatic int phys_word(input logic [23:0] va);
        return int'({page_map(va[23:12]), va[11:2]});
    endfunction

    function automatic logic [31:0] dflt_word(input int pw);
        logic [21:0] p = 22'(pw);
        return {p[21:4], 10'h2A5, p[3:0]};
    endfunction

    function automatic logic [511:0] dflt_line(input int la);
        logic [511:0] l;
        for (int i = 0; i < 16; i++) l[i*32 +: 32] = dflt_word((la << 4) | i);
        return l;
    endfunction

    function automatic logic [31:0] expect_word(input logic [23:0] va);
        int pw = phys_word(va);
        return gold.exists(pw) ? gold[pw] : dflt_word(pw);
    endfunction

    task automatic check_eq(input string req, input string what,
                            input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_access(input bit we, input logic [23:0] va,
                             input logic [31:0] wd, input int delay);
        int wait_cnt = 0;
        int cyc = 0;
        int xl_at = -1;
        bit done = 0;
        a_nrd = 0; a_nwr = 0; a_lat = -1; a_wb_la = -1; a_rd_la = -1;
        a_stall_bad = 0; a_ready_bad = 0; a_vpn_bad = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = we; req_vaddr = va; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) begin
            xl_resp_valid  = 1'b0;
            mem_resp_valid = 1'b0;
            if (resp_valid) begin
                a_rdata = resp_rdata;
                done = 1;
                if (xl_at >= 0) a_lat = cyc - xl_at;
            end else begin
                if (req_ready) a_ready_bad = 1;
                if (xl_req_valid) begin
                    if (xl_req_vpn != va[23:12]) a_vpn_bad = 1;
                    if (mem_req_valid) a_stall_bad = 1;
                    if (wait_cnt >= delay) begin
                        xl_resp_valid = 1'b1;
                        xl_resp_ppn   = page_map(xl_req_vpn);
                        xl_at = cyc;
                    end else begin
                        wait_cnt++;
                    end
                end
                if (mem_req_valid) begin
                    int la = int'(mem_req_laddr);
                    if (mem_req_write) begin
                        a_nwr++;
                        a_wb_la = la;
                        mem_lines[la] = mem_req_wline;
                    end else begin
                        a_nrd++;
                        a_rd_la = la;
                        mem_resp_rline = mem_lines.exists(la) ? mem_lines[la] : dflt_line(la);
                    end
                    mem_resp_valid = 1'b1;
                end
                if (cyc > 300) begin
                    check_eq("R10", "access did not complete", 64'(cyc), 64'd0);
                    done = 1;
                end
            end
            if (!done) begin
                @(negedge clk);
                cyc++;
            end
        end
        any_stall_bad |= a_stall_bad;
        any_ready_bad |= a_ready_bad;
        any_vpn_bad   |= a_vpn_bad;
        if (we) gold[phys_word(va)] = wd;
    endtask

    task automatic load_check(input logic [23:0] va, input int delay, input string req);
        logic [31:0] exp = expect_word(va);
        do_access(1'b0, va, 32'h0, delay);
        check_eq(req, "load data", 64'(a_rdata), 64'(exp));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL R10 watchdog expired: actual %0d expected below 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        req_valid = 1'b0; req_write = 1'b0; req_vaddr = '0; req_wdata = '0;
        xl_resp_valid = 1'b0; xl_resp_ppn = '0;
        mem_resp_valid = 1'b0; mem_resp_rline = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: idle outputs after reset
        check_eq("R1", "req_ready", 64'(req_ready), 64'd1);
        check_eq("R1", "resp_valid", 64'(resp_valid), 64'd0);
        check_eq("R1", "xl_req_valid", 64'(xl_req_valid), 64'd0);
        check_eq("R1", "mem_req_valid", 64'(mem_req_valid), 64'd0);

        // R1/R6/R2: cold miss with a clean victim
        load_check(mk_va(12'h123, 7, 3), 0, "R6");
        check_eq("R1", "cold miss refill count", 64'(a_nrd), 64'd1);
        check_eq("R6", "no write-back on clean miss", 64'(a_nwr), 64'd0);
        check_eq("R2", "refill line address", 64'(a_rd_la),
                 64'(int'({page_map(12'h123), 6'd7})));
        check_eq("R2", "translated page field", 64'(a_vpn_bad), 64'd0);
        check_eq("R10", "ready low while busy", 64'(a_ready_bad), 64'd0);

        // R3/R4: hit behind a stalled translation
        load_check(mk_va(12'h123, 7, 9), 4, "R4");
        check_eq("R4", "hit memory reads", 64'(a_nrd), 64'd0);
        check_eq("R4", "hit latency after translation", 64'(a_lat), 64'd1);
        check_eq("R3", "no memory request while stalled", 64'(a_stall_bad), 64'd0);

        // R7: store hit stays in the cache
        do_access(1'b1, mk_va(12'h123, 7, 9), 32'hDEADBEEF, 2);
        check_eq("R7", "store hit memory writes", 64'(a_nwr), 64'd0);
        check_eq("R4", "store response data", 64'(a_rdata), 64'hDEADBEEF);
        load_check(mk_va(12'h123, 7, 9), 0, "R7");

        // R5: aliased virtual page shares the physical line
        load_check(mk_va(12'hAAA, 7, 9), 1, "R5");
        check_eq("R5", "alias load refills", 64'(a_nrd), 64'd0);
        do_access(1'b1, mk_va(12'hAAA, 7, 2), 32'h12345678, 0);
        load_check(mk_va(12'h123, 7, 2), 0, "R5");
        check_eq("R5", "alias store visible without refill", 64'(a_nrd), 64'd0);

        // R9: store miss allocates and merges
        do_access(1'b1, mk_va(12'h200, 20, 5), 32'hCAFE0005, 0);
        check_eq("R9", "store miss refill count", 64'(a_nrd), 64'd1);
        load_check(mk_va(12'h200, 20, 5), 0, "R9");
        load_check(mk_va(12'h200, 20, 6), 0, "R9");
        check_eq("R9", "allocated line hits", 64'(a_nrd), 64'd0);

        // R8/R7: fill the rest of set 20, then overflow it
        for (int v = 1; v < 16; v++) load_check(mk_va(12'(12'h200 + v), 20, 0), 0, "R8");
        check_eq("R8", "set holds sixteen lines", 64'(a_nwr), 64'd0);
        load_check(mk_va(12'h210, 20, 1), 0, "R8");
        check_eq("R7", "dirty victim written back", 64'(a_nwr), 64'd1);
        check_eq("R7", "write-back line address", 64'(a_wb_la),
                 64'(int'({page_map(12'h200), 6'd20})));
        check_eq("R6", "one refill after write-back", 64'(a_nrd), 64'd1);
        load_check(mk_va(12'h201, 20, 0), 0, "R8");
        check_eq("R8", "next way still resident", 64'(a_nrd), 64'd0);
        load_check(mk_va(12'h200, 20, 5), 0, "R7");
        check_eq("R7", "written-back data refetched", 64'(a_nrd), 64'd1);
        check_eq("R8", "clean second victim", 64'(a_nwr), 64'd0);
        load_check(mk_va(12'h201, 20, 0), 0, "R8");
        check_eq("R8", "way 1 evicted in order", 64'(a_nrd), 64'd1);

        // R8: another set keeps its own pointer
        load_check(mk_va(12'h300, 7, 0), 0, "R8");
        check_eq("R8", "other set victim clean", 64'(a_nwr), 64'd0);
        load_check(mk_va(12'h123, 7, 9), 0, "R8");
        check_eq("R8", "set 7 way 0 untouched", 64'(a_nrd), 64'd0);

        // R7/R5: random mix over two conflicting sets
        void'($urandom(32'h5EED));
        for (int i = 0; i < 400; i++) begin
            logic [11:0] vpn;
            int set, w, dly;
            bit we;
            if ($urandom_range(0, 9) == 0) begin
                vpn = ($urandom_range(0, 1) == 0) ? 12'h123 : 12'hAAA;
                set = 7;
            end else begin
                vpn = 12'(12'h400 + $urandom_range(0, 21));
                set = 40 + $urandom_range(0, 1);
            end
            w   = $urandom_range(0, 15);
            dly = $urandom_range(0, 3);
            we  = ($urandom_range(0, 9) < 4);
            if (we) do_access(1'b1, mk_va(vpn, set, w), $urandom, dly);
            else    load_check(mk_va(vpn, set, w), dly, "R7");
        end
        check_eq("R3", "no memory request during any translation", 64'(any_stall_bad), 64'd0);
        check_eq("R10", "ready low in every busy cycle", 64'(any_ready_bad), 64'd0);
        check_eq("R2", "translation page in every request", 64'(any_vpn_bad), 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule